// File: doc/BRIEF.md
# Smartcard Session Activation Sequencer

This block runs the power-up and power-down ordering of a contact smartcard session. A host starts a session by pulling an active-low request line low. The block then raises enables for the supply converter, the card supply, the data-line buffers, the card clock and the card reset in a fixed ladder of steps. Each step is timed in half units of T, where T is 64 periods of a slow internal oscillator. When the host releases the request, or when a fault appears, the block runs the same ladder backwards. Card reset drops first and the converter is shut down last.

While a session is open, the block watches card presence, overcurrent, overtemperature and a filtered supply-drop flag. It reports these to the host on an active-low status line. Outside a session the same line reports whether a card is inserted. After power-up, and after any supply drop, a hold timer keeps the block idle until the supply has been good for a set time. All inputs are assumed to be synchronous to `clk`. The oscillator period is given as a whole number of `clk` cycles.

Top module: `sc_session_ctrl`

## Requirements
- R1: After reset all five card enables are 0 and status_n is 1. No session starts until vdd_good has been high for HOLD_UNITS*T with no undervoltage flag; a low request seen before that is not acted on.
- R2: One cycle after the sequencer samples req_n low, conv_en rises; this edge is t1. vcc_en rises at t1+3T/2, io_en at t1+4T, and card reset is enabled at t1+7T.
- R3: If host_rst is 0 when the session starts, clk_en rises at t1+4T together with io_en.
- R4: If host_rst is 1 when the session starts, clk_en rises one cycle after host_rst is sampled falling inside the window [t1+4T, t1+7T). With no such fall, clk_en rises at t1+7T.
- R5: card_rst stays 0 until t1+7T. From then on it follows host_rst with one cycle of delay, and host_rst no longer changes clk_en.
- R6: One cycle after req_n is sampled high during a session, card_rst is 0. clk_en falls T/2 later, io_en T later, vcc_en 3T/2 later and conv_en 5T later, and the block is then idle.
- R7: During a session, overcurrent or overtemperature drives status_n to 0 one cycle after it is sampled and starts the same falling ladder as R6. status_n stays 0 until req_n goes high.
- R8: During a session, the first sample of card absence is a fault with the timing of R7. It is held until req_n goes high, even if the card reads present again.
- R9: Outside a session, status_n is 1 one cycle after the card reads present and 0 one cycle after it reads absent. The card reads present when pres_hi is 1 or pres_lo_n is 0.
- R10: With low_thr_mode = 1, a supply drop counts only after FILT_OSC oscillator periods of consecutive low vdd_good samples; shorter drops have no effect. With low_thr_mode = 0 it counts one cycle after the first low sample. A counted drop during a session is a fault with R7 behaviour.
- R11: A low request that arrives before the falling ladder ends is not acted on. A new session needs req_n to be seen high while idle and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Session request from host, active low |
| host_rst | input | 1 | Reset level from host, copied to the card once enabled |
| pres_hi | input | 1 | Card presence, active high |
| pres_lo_n | input | 1 | Card presence, active low |
| overcur | input | 1 | Card supply overcurrent flag |
| overtemp | input | 1 | Overtemperature flag |
| vdd_good | input | 1 | Raw supply-good comparator output |
| low_thr_mode | input | 1 | 1 selects the filtered undervoltage mode |
| conv_en | output | 1 | Supply converter enable |
| vcc_en | output | 1 | Card supply ramp enable |
| io_en | output | 1 | Data-line buffer enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Reset level driven to the card |
| status_n | output | 1 | Presence / fault report to host, active low |

## Verification
Every result is tied to a single sampling edge. The host-side stimulus is one edge, and the output first changes one register stage later. Later steps follow at whole multiples of T/2 from that edge: 3, 8 and 14 half units when rising, and 1, 2, 3 and 10 half units when falling. A supply drop in filtered mode adds FILT_OSC cycles of counting before the sequencer reacts. The bench turns each stimulus into expected single-bit items, each due in one named cycle. Where a change is due, it checks both the cycle before and the cycle of the change, so an early step and a late step both show up.

// File: rtl/sc_session_pkg.sv
package sc_session_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RAMP,
    S_RUN,
    S_DOWN
  } seq_state_t;

  typedef struct packed {
    logic conv_en;
    logic vcc_en;
    logic io_en;
    logic clk_en;
    logic card_rst;
  } card_ctl_t;

  // Ladder positions in half units of T, counted from the first step.
  localparam int unsigned RAMP_VCC_H = 3;
  localparam int unsigned RAMP_IO_H  = 8;
  localparam int unsigned RAMP_RST_H = 14;
  localparam int unsigned DOWN_CLK_H = 1;
  localparam int unsigned DOWN_IO_H  = 2;
  localparam int unsigned DOWN_VCC_H = 3;
  localparam int unsigned DOWN_END_H = 10;

  function automatic logic card_present(input logic hi, input logic lo_n);
    return hi | ~lo_n;
  endfunction

endpackage

// File: rtl/sc_supply_mon.sv
module sc_supply_mon #(
  parameter int unsigned FILT_CLKS = 384,
  parameter int unsigned HOLD_CLKS = 102400
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_good,
  input  logic low_thr_mode,
  output logic uv_flag,
  output logic ready
);
  localparam int unsigned FW = $clog2(FILT_CLKS + 1);
  localparam int unsigned PW = $clog2(HOLD_CLKS + 1);

  logic          raw_uv;
  logic [FW-1:0] filt_cnt;
  logic [PW-1:0] hold_cnt;

  assign raw_uv = ~vdd_good;

  // Undervoltage filter: counts consecutive low samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_cnt <= '0;
      uv_flag  <= 1'b0;
    end else begin
      if (!raw_uv)
        filt_cnt <= '0;
      else if (filt_cnt != FW'(FILT_CLKS))
        filt_cnt <= filt_cnt + 1'b1;
      if (low_thr_mode)
        uv_flag <= raw_uv && (filt_cnt >= FW'(FILT_CLKS - 1));
      else
        uv_flag <= raw_uv;
    end
  end

  // Power-on hold: supply must stay clean for HOLD_CLKS cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      ready    <= 1'b0;
    end else if (uv_flag) begin
      hold_cnt <= '0;
      ready    <= 1'b0;
    end else if (hold_cnt == PW'(HOLD_CLKS - 1)) begin
      ready    <= 1'b1;
    end else begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R10
  uv_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_flag) |-> $past(raw_uv));

  // R1
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> !ready);

endmodule

// File: rtl/sc_half_timer.sv
module sc_half_timer #(
  parameter int unsigned HALF_CLKS = 128,
  parameter int unsigned HW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [HW-1:0] half_cnt,
  output logic          half_tick
);
  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [CW-1:0] clk_cnt;

  assign half_tick = run && !clear && (clk_cnt == CW'(HALF_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      clk_cnt  <= '0;
      half_cnt <= '0;
    end else if (run) begin
      if (half_tick) begin
        clk_cnt  <= '0;
        half_cnt <= half_cnt + 1'b1;
      end else begin
        clk_cnt  <= clk_cnt + 1'b1;
      end
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick || (HALF_CLKS == 1));

endmodule

// File: rtl/sc_fault_watch.sv
module sc_fault_watch
  import sc_session_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_session,
  input  logic pres_hi,
  input  logic pres_lo_n,
  input  logic overcur,
  input  logic overtemp,
  input  logic uv_flag,
  input  logic req_n,
  output logic fault,
  output logic status_n
);
  logic present;
  logic lock;

  assign present = card_present(pres_hi, pres_lo_n);
  assign fault   = in_session && (!present || overcur || overtemp || uv_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock     <= 1'b0;
      status_n <= 1'b1;
    end else begin
      if (fault)
        lock <= 1'b1;
      else if (req_n)
        lock <= 1'b0;

      if (fault || (lock && !req_n))
        status_n <= 1'b0;
      else if (in_session)
        status_n <= 1'b1;
      else
        status_n <= present;
    end
  end

  // R7
  fault_exit_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!status_n && !in_session));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!status_n && !req_n && !in_session && $past(!req_n)) |=> (!status_n || req_n));

endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_session_pkg::*;
#(
  parameter int unsigned HW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_n,
  input  logic          host_rst,
  input  logic          ready,
  input  logic          fault,
  input  logic [HW-1:0] half_cnt,
  input  logic          half_tick,
  output logic          tmr_clear,
  output logic          tmr_run,
  output logic          in_session,
  output card_ctl_t     ctl
);
  seq_state_t    state;
  logic          armed;
  logic          wait_fall;
  logic          host_rst_q;
  logic          start;
  logic          leave;
  logic          fall_seen;
  logic [HW-1:0] next_half;

  assign next_half  = half_cnt + 1'b1;
  assign in_session = (state == S_RAMP) || (state == S_RUN);
  assign start      = (state == S_IDLE) && armed && !req_n && ready;
  assign leave      = in_session && (fault || req_n);
  assign tmr_clear  = start || leave;
  assign tmr_run    = (state == S_RAMP) || (state == S_DOWN);
  assign fall_seen  = host_rst_q && !host_rst;

  function automatic logic at_step(input int unsigned n);
    return half_tick && (next_half == HW'(n));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      armed      <= 1'b0;
      wait_fall  <= 1'b0;
      host_rst_q <= 1'b0;
      ctl        <= '0;
    end else begin
      host_rst_q <= host_rst;
      if (leave) begin
        state        <= S_DOWN;
        ctl.card_rst <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (start) begin
              state       <= S_RAMP;
              armed       <= 1'b0;
              wait_fall   <= host_rst;
              ctl.conv_en <= 1'b1;
            end else if (req_n) begin
              armed <= 1'b1;
            end
          end
          S_RAMP: begin
            if (wait_fall && (half_cnt >= HW'(RAMP_IO_H)) && fall_seen)
              ctl.clk_en <= 1'b1;
            if (at_step(RAMP_VCC_H))
              ctl.vcc_en <= 1'b1;
            if (at_step(RAMP_IO_H)) begin
              ctl.io_en <= 1'b1;
              if (!wait_fall)
                ctl.clk_en <= 1'b1;
            end
            if (at_step(RAMP_RST_H)) begin
              state        <= S_RUN;
              ctl.clk_en   <= 1'b1;
              ctl.card_rst <= host_rst;
            end
          end
          S_RUN: begin
            ctl.card_rst <= host_rst;
          end
          S_DOWN: begin
            ctl.card_rst <= 1'b0;
            if (at_step(DOWN_CLK_H))
              ctl.clk_en <= 1'b0;
            if (at_step(DOWN_IO_H))
              ctl.io_en <= 1'b0;
            if (at_step(DOWN_VCC_H))
              ctl.vcc_en <= 1'b0;
            if (at_step(DOWN_END_H)) begin
              ctl.conv_en <= 1'b0;
              state       <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R6
  vcc_needs_conv_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.vcc_en |-> ctl.conv_en);

  // R6
  io_needs_vcc_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.io_en |-> ctl.vcc_en);

  // R3
  clk_needs_io_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.clk_en |-> ctl.io_en);

  // R5
  rst_needs_clk_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.card_rst |-> ctl.clk_en);

  // R5
  ramp_rst_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RAMP) |-> !ctl.card_rst);

  // R1
  no_start_unready_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !ready && !ctl.conv_en) |=> !ctl.conv_en);

endmodule

// File: rtl/sc_session_ctrl.sv
module sc_session_ctrl
  import sc_session_pkg::*;
#(
  parameter int unsigned OSC_DIV    = 4,
  parameter int unsigned UNIT_OSC   = 64,
  parameter int unsigned HOLD_UNITS = 400,
  parameter int unsigned FILT_OSC   = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  input  logic host_rst,
  input  logic pres_hi,
  input  logic pres_lo_n,
  input  logic overcur,
  input  logic overtemp,
  input  logic vdd_good,
  input  logic low_thr_mode,
  output logic conv_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic status_n
);
  localparam int unsigned HALF_CLKS = OSC_DIV * UNIT_OSC / 2;
  localparam int unsigned FILT_CLKS = FILT_OSC * OSC_DIV;
  localparam int unsigned HOLD_CLKS = HOLD_UNITS * UNIT_OSC * OSC_DIV;
  localparam int unsigned HW        = $clog2(RAMP_RST_H + 1);

  logic          uv_flag;
  logic          ready;
  logic          fault;
  logic          in_session;
  logic          tmr_clear;
  logic          tmr_run;
  logic          half_tick;
  logic [HW-1:0] half_cnt;
  card_ctl_t     ctl;

  sc_supply_mon #(
    .FILT_CLKS(FILT_CLKS),
    .HOLD_CLKS(HOLD_CLKS)
  ) u_supply (
    .clk         (clk),
    .rst         (rst),
    .vdd_good    (vdd_good),
    .low_thr_mode(low_thr_mode),
    .uv_flag     (uv_flag),
    .ready       (ready)
  );

  sc_half_timer #(
    .HALF_CLKS(HALF_CLKS),
    .HW       (HW)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (tmr_clear),
    .run      (tmr_run),
    .half_cnt (half_cnt),
    .half_tick(half_tick)
  );

  sc_fault_watch u_watch (
    .clk       (clk),
    .rst       (rst),
    .in_session(in_session),
    .pres_hi   (pres_hi),
    .pres_lo_n (pres_lo_n),
    .overcur   (overcur),
    .overtemp  (overtemp),
    .uv_flag   (uv_flag),
    .req_n     (req_n),
    .fault     (fault),
    .status_n  (status_n)
  );

  sc_seq_fsm #(
    .HW(HW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_n     (req_n),
    .host_rst  (host_rst),
    .ready     (ready),
    .fault     (fault),
    .half_cnt  (half_cnt),
    .half_tick (half_tick),
    .tmr_clear (tmr_clear),
    .tmr_run   (tmr_run),
    .in_session(in_session),
    .ctl       (ctl)
  );

  assign conv_en  = ctl.conv_en;
  assign vcc_en   = ctl.vcc_en;
  assign io_en    = ctl.io_en;
  assign clk_en   = ctl.clk_en;
  assign card_rst = ctl.card_rst;

endmodule

// File: tb/test_sc_session_ctrl.sv
module test_sc_session_ctrl;
  localparam int OSC_DIV    = 1;
  localparam int UNIT_OSC   = 8;
  localparam int HOLD_UNITS = 4;
  localparam int FILT_OSC   = 6;
  localparam int H          = OSC_DIV * UNIT_OSC / 2;
  localparam int WD_CYCLES  = 8000;

  localparam int B_CONV = 5, B_VCC = 4, B_IO = 3, B_CLK = 2, B_RST = 1, B_STAT = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1, host_rst = 1'b0, pres_hi = 1'b1, pres_lo_n = 1'b1;
  logic overcur = 1'b0, overtemp = 1'b0, vdd_good = 1'b1, low_thr_mode = 1'b0;
  logic conv_en, vcc_en, io_en, clk_en, card_rst, status_n;

  sc_session_ctrl #(
    .OSC_DIV(OSC_DIV), .UNIT_OSC(UNIT_OSC), .HOLD_UNITS(HOLD_UNITS), .FILT_OSC(FILT_OSC)
  ) i_sc_session_ctrl (
    .clk(clk), .rst(rst), .req_n(req_n), .host_rst(host_rst), .pres_hi(pres_hi),
    .pres_lo_n(pres_lo_n), .overcur(overcur), .overtemp(overtemp), .vdd_good(vdd_good),
    .low_thr_mode(low_thr_mode), .conv_en(conv_en), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .status_n(status_n)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  typedef struct {
    int    at;
    int    idx;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  logic [5:0] obs;
  assign obs = {conv_en, vcc_en, io_en, clk_en, card_rst, status_n};

  task automatic expect_at(input int at, input int idx, input logic val, input string tag);
    exp_t e;
    int   i;
    e.at = at; e.idx = idx; e.val = val; e.tag = tag;
    i = 0;
    while (i < q.size() && q[i].at <= at) i++;
    q.insert(i, e);
  endtask

  // Monitor: pops due items and compares them with the outputs.
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (e.at < cyc || obs[e.idx] !== e.val) begin
          n_fail++;
          $display("FAIL %s cycle %0d bit %0d: actual %b expected %b",
                   e.tag, e.at, e.idx, obs[e.idx], e.val);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > WD_CYCLES) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic go(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // Drive the request low now and queue the rising ladder (R2, R3).
  task automatic start_session(input logic hold_rst, output int k);
    host_rst = hold_rst;
    req_n    = 1'b0;
    k        = cyc + 1;
    expect_at(k,             B_CONV, 1'b1, "R2 conv_en at t1");
    expect_at(k + 3*H - 1,   B_VCC,  1'b0, "R2 vcc_en before 3T/2");
    expect_at(k + 3*H,       B_VCC,  1'b1, "R2 vcc_en at 3T/2");
    expect_at(k + 8*H - 1,   B_IO,   1'b0, "R2 io_en before 4T");
    expect_at(k + 8*H,       B_IO,   1'b1, "R2 io_en at 4T");
    if (!hold_rst) begin
      expect_at(k + 8*H - 1, B_CLK,  1'b0, "R3 clk_en before 4T");
      expect_at(k + 8*H,     B_CLK,  1'b1, "R3 clk_en at 4T");
    end
  endtask

  // Falling ladder starting at edge d.
  task automatic expect_down(input int d, input string tag);
    expect_at(d,            B_RST,  1'b0, {tag, " card_rst low"});
    expect_at(d + H - 1,    B_CLK,  1'b1, {tag, " clk before T/2"});
    expect_at(d + H,        B_CLK,  1'b0, {tag, " clk off T/2"});
    expect_at(d + 2*H - 1,  B_IO,   1'b1, {tag, " io before T"});
    expect_at(d + 2*H,      B_IO,   1'b0, {tag, " io off T"});
    expect_at(d + 3*H - 1,  B_VCC,  1'b1, {tag, " vcc before 3T/2"});
    expect_at(d + 3*H,      B_VCC,  1'b0, {tag, " vcc off 3T/2"});
    expect_at(d + 10*H - 1, B_CONV, 1'b1, {tag, " conv before 5T"});
    expect_at(d + 10*H,     B_CONV, 1'b0, {tag, " conv off 5T"});
  endtask

  initial begin
    int k, c, c2, d, f;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    expect_at(1, B_CONV, 1'b0, "R1 reset conv");
    expect_at(1, B_VCC,  1'b0, "R1 reset vcc");
    expect_at(1, B_IO,   1'b0, "R1 reset io");
    expect_at(1, B_CLK,  1'b0, "R1 reset clk");
    expect_at(1, B_RST,  1'b0, "R1 reset card_rst");
    expect_at(1, B_STAT, 1'b1, "R1 reset status");

    // R1: request during the power-on hold is not acted on
    go(3);
    req_n = 1'b0;
    expect_at(10, B_CONV, 1'b0, "R1 hold blocks start");
    expect_at(24, B_CONV, 1'b0, "R1 hold blocks start late");
    go(25);
    req_n = 1'b1;

    // R9: presence reporting outside a session
    go(60);
    pres_hi = 1'b0;
    expect_at(61, B_STAT, 1'b0, "R9 absent");
    go(62);
    pres_lo_n = 1'b0;
    expect_at(63, B_STAT, 1'b1, "R9 present via active-low input");
    go(64);
    pres_hi = 1'b1; pres_lo_n = 1'b1;
    drain();

    // R2/R3/R5/R6/R11: automatic clock session, normal release
    go(70);
    start_session(1'b0, k);
    expect_at(k + 14*H - 1, B_RST, 1'b0, "R5 card_rst held before 7T");
    expect_at(k + 14*H,     B_RST, 1'b1, "R5 card_rst enabled at 7T");
    go(k + 9*H);
    host_rst = 1'b1;
    go(k + 14*H + 2);
    host_rst = 1'b0;
    expect_at(k + 14*H + 3, B_RST, 1'b0, "R5 card_rst follows low");
    expect_at(k + 14*H + 3, B_CLK, 1'b1, "R5 clock unaffected by host_rst");
    go(k + 14*H + 4);
    host_rst = 1'b1;
    expect_at(k + 14*H + 5, B_RST, 1'b1, "R5 card_rst follows high");
    go(k + 14*H + 8);
    req_n = 1'b1;
    d = cyc + 1;
    expect_down(d, "R6");
    expect_at(d + 10*H + 6, B_CONV, 1'b0, "R11 no restart after ladder");
    expect_at(d + 10*H + 6, B_VCC,  1'b0, "R11 supply stays off");
    go(d + 2*H);
    req_n = 1'b0;
    go(d + 10*H + 8);
    req_n = 1'b1; host_rst = 1'b0;
    drain();

    // R4/R7: deferred clock, then overcurrent fault
    go(cyc + 4);
    start_session(1'b1, k);
    expect_at(k + 8*H + 2, B_CLK, 1'b0, "R4 clock waits for fall");
    expect_at(k + 8*H + 3, B_CLK, 1'b1, "R4 clock on host_rst fall");
    expect_at(k + 14*H,    B_RST, 1'b0, "R5 card_rst copies low host_rst");
    go(k + 8*H + 2);
    host_rst = 1'b0;
    go(k + 14*H + 5);
    overcur = 1'b1;
    f = cyc + 1;
    expect_at(f, B_STAT, 1'b0, "R7 overcurrent status");
    expect_down(f, "R7");
    expect_at(f + 10*H + 3, B_STAT, 1'b0, "R7 status held while request low");
    expect_at(f + 10*H + 5, B_STAT, 1'b1, "R7 status released by request high");
    go(f);
    overcur = 1'b0;
    go(f + 10*H + 4);
    req_n = 1'b1;
    drain();

    // R4/R8: no fall so clock forced at 7T, then card removal
    go(cyc + 4);
    start_session(1'b1, k);
    expect_at(k + 14*H - 1, B_CLK, 1'b0, "R4 no fall, clock still off");
    expect_at(k + 14*H,     B_CLK, 1'b1, "R4 clock forced at 7T");
    expect_at(k + 14*H,     B_RST, 1'b1, "R5 card_rst copies high host_rst");
    go(k + 14*H + 3);
    pres_hi = 1'b0;
    f = cyc + 1;
    expect_at(f, B_STAT, 1'b0, "R8 removal status");
    expect_down(f, "R8");
    expect_at(f + 10*H + 2, B_STAT, 1'b0, "R8 removal latched after reinsertion");
    expect_at(f + 10*H + 5, B_STAT, 1'b1, "R8 latch cleared by request high");
    go(f);
    pres_hi = 1'b1;
    go(f + 10*H + 4);
    req_n = 1'b1; host_rst = 1'b0;
    drain();

    // R10: filtered mode, short drop ignored, long drop is a fault
    low_thr_mode = 1'b1;
    go(cyc + 4);
    start_session(1'b0, k);
    go(k + 14*H + 2);
    c = cyc;
    vdd_good = 1'b0;
    expect_at(c + 10, B_STAT, 1'b1, "R10 short drop ignored status");
    expect_at(c + 10, B_CONV, 1'b1, "R10 short drop ignored session");
    go(c + 4);
    vdd_good = 1'b1;
    go(c + 12);
    c2 = cyc;
    vdd_good = 1'b0;
    expect_at(c2 + 6, B_STAT, 1'b1, "R10 filter still counting");
    expect_at(c2 + 7, B_STAT, 1'b0, "R10 filtered drop fault");
    expect_down(c2 + 7, "R10");
    go(c2 + 10);
    vdd_good = 1'b1;
    go(c2 + 7 + 10*H + 2);
    req_n = 1'b1;
    drain();
    go(cyc + 50);

    // R10: immediate mode
    low_thr_mode = 1'b0;
    start_session(1'b0, k);
    go(k + 14*H + 2);
    c = cyc;
    vdd_good = 1'b0;
    expect_at(c + 1, B_STAT, 1'b1, "R10 immediate one register");
    expect_at(c + 2, B_STAT, 1'b0, "R10 immediate drop fault");
    expect_down(c + 2, "R10 immediate");
    go(c + 1);
    vdd_good = 1'b1;
    go(c + 2 + 10*H + 2);
    req_n = 1'b1;
    drain();
    go(cyc + 50);

    // R7: overtemperature
    start_session(1'b0, k);
    go(k + 14*H + 2);
    c = cyc;
    overtemp = 1'b1;
    expect_at(c + 1, B_STAT, 1'b0, "R7 overtemp status");
    expect_down(c + 1, "R7 overtemp");
    go(c + 1);
    overtemp = 1'b0;
    go(c + 1 + 10*H + 2);
    req_n = 1'b1;
    drain();

    go(cyc + 3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule